// File: doc/BRIEF.md
# Data Width Adapting Bridge

This bridge joins one memory-mapped master port to one slave port of a different data width, so that the master never sees the mismatch. Two elaboration-time modes are available. The sizing mode suits memories: a master wider than the slave has each access cut into consecutive slave accesses, and a master narrower than the slave has its bytes steered onto the right lanes of the wide slave word. The native mode suits register files: exactly one slave access is made, with zero padding of read data or dropping of the low address bits.

Both ports use byte addresses. The master holds its request until the bridge lowers `m_waitreq`. The slave completes an access in the cycle where `s_waitreq` is low. A small sequencer controls every access. It has three states: IDLE, XFER and RESP. Its transitions are IDLE to XFER when a request is seen (the address, data and enables are captured). XFER stays in XFER to move to the next sub-access when the slave finishes a sub-access that is not the last. XFER goes to RESP when the last sub-access finishes. RESP always goes back to IDLE. Only in RESP does `m_waitreq` go low, and only there is `m_rdvalid` raised for a read.

Top module: `wbr_bridge`

## Requirements
- R1: While reset is held and after it is released with no request, `m_waitreq` is 1, `m_rdvalid` is 0 and neither `s_read` nor `s_write` is asserted.
- R2: In sizing mode with MST_W > SLV_W, each master access becomes MST_W/SLV_W slave accesses. Their addresses step upward by SLV_W/8 from the master word address. Slave word k carries master data bits [k*SLV_W +: SLV_W], so the lowest slave word is the least significant part.
- R3: In sizing mode with MST_W > SLV_W, sub-access k drives `s_be` = `m_be[k*SB +: SB]`, where SB = SLV_W/8. A sub-access whose slice is all zero is still issued, with `s_be` all zero.
- R4: In sizing mode with MST_W < SLV_W, a write goes to the slave word holding the master address. It drives only byte enables shifted to lane L = (m_addr mod SLV_W/8)/(MST_W/8), and the write data is shifted by L*MST_W bits.
- R5: In sizing mode with MST_W < SLV_W, read data returns `s_rdata` shifted down by L*MST_W bits.
- R6: In native mode with MST_W > SLV_W, one slave access is made at the master word address. It carries the low SLV_W data bits and low SB enables, and read data has its upper MST_W-SLV_W bits zero.
- R7: In native mode with MST_W < SLV_W, the address bits below the slave word size are cleared. Data and enables use the low lanes with no shift, so two master addresses in one slave word reach the same bytes.
- R8: `m_waitreq` stays high from the request until the last slave sub-access has completed, and is then low for exactly one cycle. A request of N sub-accesses with W slave wait cycles each holds `m_waitreq` high for 1+N*(W+1) cycles.
- R9: A read raises `m_rdvalid` for exactly one cycle, the cycle `m_waitreq` is low, with the fully assembled word. A write never raises it.
- R10: While the slave holds `s_waitreq` high, the bridge keeps its slave request, address, enables and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | AW | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | MST_W | Master write data |
| m_be | input | MST_W/8 | Master byte enables |
| m_rdata | output | MST_W | Assembled read data |
| m_rdvalid | output | 1 | Read data valid, one cycle per read |
| m_waitreq | output | 1 | High while the master must hold its request |
| s_addr | output | AW | Slave byte address |
| s_read | output | 1 | Slave read request |
| s_write | output | 1 | Slave write request |
| s_wdata | output | SLV_W | Slave write data |
| s_be | output | SLV_W/8 | Slave byte enables |
| s_rdata | input | SLV_W | Slave read data |
| s_waitreq | input | 1 | Slave stall |

## Verification
Every cycle, assertions check several things. The slave request and its fields hold steady under a slave stall. The valid pulse lasts a single cycle and coincides with the release of `m_waitreq`. The release only follows a completed slave access. In the splitting configuration, each following sub-access address steps up by one slave word. Only the bench's scenarios can show the values themselves. These are the bytes landing in the right slave words and lanes, the enable slices including an all-zero one, zero padding and address dropping in native mode, and the exact stall length with several wait cycles per sub-access. The bench runs four bridges: both modes, each in both width directions.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_RESP = 2'd2
    } wbr_state_t;

    typedef enum logic {
        SIZE_DYNAMIC = 1'b0,
        SIZE_NATIVE  = 1'b1
    } wbr_mode_t;
endpackage

// File: rtl/wbr_seq.sv
module wbr_seq
    import wbr_pkg::*;
#(
    parameter int BEATS = 2,
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          s_waitreq,
    output wbr_state_t    state,
    output logic [BW-1:0] beat,
    output logic          capture,
    output logic          beat_done,
    output logic          last
);
    wbr_state_t state_nx;
    logic [BW-1:0] beat_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        beat_nx   = beat;
        capture   = 1'b0;
        beat_done = 1'b0;
        last      = (beat == BW'(BEATS - 1));
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    capture  = 1'b1;
                    beat_nx  = '0;
                    state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (!s_waitreq) begin
                    beat_done = 1'b1;
                    if (last) begin
                        state_nx = ST_RESP;
                    end else begin
                        beat_nx = beat + 1'b1;
                    end
                end
            end
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // R8: a response cycle only directly follows the final completed sub-access
    assert_resp_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP) |-> $past(state == ST_XFER && !s_waitreq && last));

    // R8: the response state lasts a single cycle
    assert_resp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP) |=> (state == ST_IDLE));
endmodule

// File: rtl/wbr_lane.sv
module wbr_lane
    import wbr_pkg::*;
#(
    parameter int        AW    = 16,
    parameter int        MST_W = 32,
    parameter int        SLV_W = 16,
    parameter wbr_mode_t MODE  = SIZE_DYNAMIC,
    parameter int        BW    = 1,
    localparam int       MB    = MST_W / 8,
    localparam int       SB    = SLV_W / 8
) (
    input  logic [AW-1:0]    addr,
    input  logic [MST_W-1:0] wdata,
    input  logic [MB-1:0]    be,
    input  logic [BW-1:0]    beat,
    input  logic [SLV_W-1:0] s_rdata,
    input  logic [MST_W-1:0] rbuf_in,
    output logic [AW-1:0]    s_addr,
    output logic [SLV_W-1:0] s_wdata,
    output logic [SB-1:0]    s_be,
    output logic [MST_W-1:0] rbuf_next
);
    localparam logic [AW-1:0] MST_MASK = ~AW'(MB - 1);
    localparam logic [AW-1:0] SLV_MASK = ~AW'(SB - 1);

    wire unused_lane = ^{addr, wdata, be, beat, rbuf_in, s_rdata};

    generate
        if (MST_W > SLV_W && MODE == SIZE_DYNAMIC) begin : g_split
            always_comb begin
                s_addr    = (addr & MST_MASK) + (AW'(beat) * AW'(SB));
                s_wdata   = wdata[beat*SLV_W +: SLV_W];
                s_be      = be[beat*SB +: SB];
                rbuf_next = rbuf_in;
                rbuf_next[beat*SLV_W +: SLV_W] = s_rdata;
            end
        end else if (MST_W > SLV_W) begin : g_pad
            always_comb begin
                s_addr    = addr & MST_MASK;
                s_wdata   = wdata[SLV_W-1:0];
                s_be      = be[SB-1:0];
                rbuf_next = MST_W'(s_rdata);
            end
        end else if (MST_W < SLV_W && MODE == SIZE_DYNAMIC) begin : g_steer
            localparam int LW = $clog2(SLV_W / MST_W);
            logic [LW-1:0] lane;
            always_comb begin
                lane      = LW'((addr & AW'(SB - 1)) >> $clog2(MB));
                s_addr    = addr & SLV_MASK;
                s_be      = SB'(be) << (lane * MB);
                s_wdata   = SLV_W'(wdata) << (lane * MST_W);
                rbuf_next = MST_W'(s_rdata >> (lane * MST_W));
            end
        end else if (MST_W < SLV_W) begin : g_trunc
            always_comb begin
                s_addr    = addr & SLV_MASK;
                s_be      = SB'(be);
                s_wdata   = SLV_W'(wdata);
                rbuf_next = s_rdata[MST_W-1:0];
            end
        end else begin : g_same
            always_comb begin
                s_addr    = addr;
                s_be      = SB'(be);
                s_wdata   = SLV_W'(wdata);
                rbuf_next = MST_W'(s_rdata);
            end
        end
    endgenerate
endmodule

// File: rtl/wbr_bridge.sv
module wbr_bridge
    import wbr_pkg::*;
#(
    parameter int        AW    = 16,
    parameter int        MST_W = 32,
    parameter int        SLV_W = 16,
    parameter wbr_mode_t MODE  = SIZE_DYNAMIC,
    localparam int       MB    = MST_W / 8,
    localparam int       SB    = SLV_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    m_addr,
    input  logic             m_read,
    input  logic             m_write,
    input  logic [MST_W-1:0] m_wdata,
    input  logic [MB-1:0]    m_be,
    output logic [MST_W-1:0] m_rdata,
    output logic             m_rdvalid,
    output logic             m_waitreq,
    output logic [AW-1:0]    s_addr,
    output logic             s_read,
    output logic             s_write,
    output logic [SLV_W-1:0] s_wdata,
    output logic [SB-1:0]    s_be,
    input  logic [SLV_W-1:0] s_rdata,
    input  logic             s_waitreq
);
    localparam int BEATS = (MODE == SIZE_DYNAMIC && MST_W > SLV_W) ? (MST_W / SLV_W) : 1;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    wbr_state_t    state;
    logic [BW-1:0] beat;
    logic          capture, beat_done, last;

    logic [AW-1:0]    cap_addr;
    logic [MST_W-1:0] cap_wdata;
    logic [MB-1:0]    cap_be;
    logic             cap_wr;
    logic [MST_W-1:0] rbuf, rbuf_next;

    wbr_seq #(.BEATS(BEATS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (m_read | m_write),
        .s_waitreq (s_waitreq),
        .state     (state),
        .beat      (beat),
        .capture   (capture),
        .beat_done (beat_done),
        .last      (last)
    );

    wbr_lane #(
        .AW(AW), .MST_W(MST_W), .SLV_W(SLV_W), .MODE(MODE), .BW(BW)
    ) u_lane (
        .addr      (cap_addr),
        .wdata     (cap_wdata),
        .be        (cap_be),
        .beat      (beat),
        .s_rdata   (s_rdata),
        .rbuf_in   (rbuf),
        .s_addr    (s_addr),
        .s_wdata   (s_wdata),
        .s_be      (s_be),
        .rbuf_next (rbuf_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_be    <= '0;
            cap_wr    <= 1'b0;
            rbuf      <= '0;
        end else begin
            if (capture) begin
                cap_addr  <= m_addr;
                cap_wdata <= m_wdata;
                cap_be    <= m_be;
                cap_wr    <= m_write;
                rbuf      <= '0;
            end else if (beat_done && !cap_wr) begin
                rbuf <= rbuf_next;
            end
        end
    end

    always_comb begin
        s_read    = (state == ST_XFER) && !cap_wr;
        s_write   = (state == ST_XFER) && cap_wr;
        m_waitreq = (state != ST_RESP);
        m_rdvalid = (state == ST_RESP) && !cap_wr;
        m_rdata   = rbuf;
    end

    // R10: a stalled slave request keeps all its fields
    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_waitreq) |=>
            ((s_read || s_write) && $stable(s_addr) && $stable(s_be) && $stable(s_wdata)));

    // R9: valid lasts one cycle and only with the release
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_rdvalid |-> (!m_waitreq ##1 !m_rdvalid));

    // R8: the master is released only after a slave access has completed
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_waitreq) |-> $past((s_read || s_write) && !s_waitreq));

    generate
        if (BEATS > 1) begin : g_chk_split
            // R2: the next sub-access address is one slave word higher
            assert_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (beat_done && !last) |=> (s_addr == $past(s_addr) + AW'(SB)));
        end
    endgenerate
endmodule

// File: tb/wbr_bridge_test.sv
module wbr_slave_model #(
    parameter int W = 16,
    parameter int AW = 16,
    parameter int WAITS = 0,
    localparam int B = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [B-1:0]  be,
    output logic [W-1:0]  rdata,
    output logic          waitreq,
    output int            ntx,
    output logic [B-1:0]  last_be,
    output logic [B-1:0]  prev_be
);
    logic [W-1:0] mem [16];
    logic [3:0] cnt;
    logic [3:0] idx;

    assign idx     = 4'(addr >> $clog2(B));
    assign rdata   = mem[idx];
    assign waitreq = (rd | wr) && (cnt != 4'(WAITS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            cnt     <= '0;
            ntx     <= 0;
            last_be <= '0;
            prev_be <= '0;
        end else if (rd | wr) begin
            if (cnt == 4'(WAITS)) begin
                cnt     <= '0;
                ntx     <= ntx + 1;
                prev_be <= last_be;
                last_be <= be;
                if (wr) begin
                    for (int b = 0; b < B; b++)
                        if (be[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

module wbr_bridge_test;
    import wbr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // wide masters: index 0 = uut (sizing, 32->16, 2 waits), 1 = uut_wn (native, 32->16)
    logic [15:0] w_addr [2];
    logic        w_rd [2], w_wr [2], w_valid [2], w_wait [2];
    logic [31:0] w_wdata [2], w_rdata [2];
    logic [3:0]  w_be [2];
    logic [15:0] ws_addr [2];
    logic        ws_rd [2], ws_wr [2], ws_wait [2];
    logic [15:0] ws_wdata [2], ws_rdata [2];
    logic [1:0]  ws_be [2], ws_last [2], ws_prev [2];
    int          ws_ntx [2];

    // narrow masters: index 0 = uut_nd (sizing, 16->32), 1 = uut_nn (native, 16->32)
    logic [15:0] n_addr [2];
    logic        n_rd [2], n_wr [2], n_valid [2], n_wait [2];
    logic [15:0] n_wdata [2], n_rdata [2];
    logic [1:0]  n_be [2];
    logic [15:0] ns_addr [2];
    logic        ns_rd [2], ns_wr [2], ns_wait [2];
    logic [31:0] ns_wdata [2], ns_rdata [2];
    logic [3:0]  ns_be [2], ns_last [2], ns_prev [2];
    int          ns_ntx [2];

    wbr_bridge #(.AW(16), .MST_W(32), .SLV_W(16), .MODE(SIZE_DYNAMIC)) uut (
        .clk(clk), .rst_n(rst_n), .m_addr(w_addr[0]), .m_read(w_rd[0]), .m_write(w_wr[0]),
        .m_wdata(w_wdata[0]), .m_be(w_be[0]), .m_rdata(w_rdata[0]), .m_rdvalid(w_valid[0]),
        .m_waitreq(w_wait[0]), .s_addr(ws_addr[0]), .s_read(ws_rd[0]), .s_write(ws_wr[0]),
        .s_wdata(ws_wdata[0]), .s_be(ws_be[0]), .s_rdata(ws_rdata[0]), .s_waitreq(ws_wait[0]));
    wbr_slave_model #(.W(16), .AW(16), .WAITS(2)) sw0 (
        .clk(clk), .rst_n(rst_n), .rd(ws_rd[0]), .wr(ws_wr[0]), .addr(ws_addr[0]),
        .wdata(ws_wdata[0]), .be(ws_be[0]), .rdata(ws_rdata[0]), .waitreq(ws_wait[0]),
        .ntx(ws_ntx[0]), .last_be(ws_last[0]), .prev_be(ws_prev[0]));

    wbr_bridge #(.AW(16), .MST_W(32), .SLV_W(16), .MODE(SIZE_NATIVE)) uut_wn (
        .clk(clk), .rst_n(rst_n), .m_addr(w_addr[1]), .m_read(w_rd[1]), .m_write(w_wr[1]),
        .m_wdata(w_wdata[1]), .m_be(w_be[1]), .m_rdata(w_rdata[1]), .m_rdvalid(w_valid[1]),
        .m_waitreq(w_wait[1]), .s_addr(ws_addr[1]), .s_read(ws_rd[1]), .s_write(ws_wr[1]),
        .s_wdata(ws_wdata[1]), .s_be(ws_be[1]), .s_rdata(ws_rdata[1]), .s_waitreq(ws_wait[1]));
    wbr_slave_model #(.W(16), .AW(16), .WAITS(0)) sw1 (
        .clk(clk), .rst_n(rst_n), .rd(ws_rd[1]), .wr(ws_wr[1]), .addr(ws_addr[1]),
        .wdata(ws_wdata[1]), .be(ws_be[1]), .rdata(ws_rdata[1]), .waitreq(ws_wait[1]),
        .ntx(ws_ntx[1]), .last_be(ws_last[1]), .prev_be(ws_prev[1]));

    wbr_bridge #(.AW(16), .MST_W(16), .SLV_W(32), .MODE(SIZE_DYNAMIC)) uut_nd (
        .clk(clk), .rst_n(rst_n), .m_addr(n_addr[0]), .m_read(n_rd[0]), .m_write(n_wr[0]),
        .m_wdata(n_wdata[0]), .m_be(n_be[0]), .m_rdata(n_rdata[0]), .m_rdvalid(n_valid[0]),
        .m_waitreq(n_wait[0]), .s_addr(ns_addr[0]), .s_read(ns_rd[0]), .s_write(ns_wr[0]),
        .s_wdata(ns_wdata[0]), .s_be(ns_be[0]), .s_rdata(ns_rdata[0]), .s_waitreq(ns_wait[0]));
    wbr_slave_model #(.W(32), .AW(16), .WAITS(1)) sn0 (
        .clk(clk), .rst_n(rst_n), .rd(ns_rd[0]), .wr(ns_wr[0]), .addr(ns_addr[0]),
        .wdata(ns_wdata[0]), .be(ns_be[0]), .rdata(ns_rdata[0]), .waitreq(ns_wait[0]),
        .ntx(ns_ntx[0]), .last_be(ns_last[0]), .prev_be(ns_prev[0]));

    wbr_bridge #(.AW(16), .MST_W(16), .SLV_W(32), .MODE(SIZE_NATIVE)) uut_nn (
        .clk(clk), .rst_n(rst_n), .m_addr(n_addr[1]), .m_read(n_rd[1]), .m_write(n_wr[1]),
        .m_wdata(n_wdata[1]), .m_be(n_be[1]), .m_rdata(n_rdata[1]), .m_rdvalid(n_valid[1]),
        .m_waitreq(n_wait[1]), .s_addr(ns_addr[1]), .s_read(ns_rd[1]), .s_write(ns_wr[1]),
        .s_wdata(ns_wdata[1]), .s_be(ns_be[1]), .s_rdata(ns_rdata[1]), .s_waitreq(ns_wait[1]));
    wbr_slave_model #(.W(32), .AW(16), .WAITS(0)) sn1 (
        .clk(clk), .rst_n(rst_n), .rd(ns_rd[1]), .wr(ns_wr[1]), .addr(ns_addr[1]),
        .wdata(ns_wdata[1]), .be(ns_be[1]), .rdata(ns_rdata[1]), .waitreq(ns_wait[1]),
        .ntx(ns_ntx[1]), .last_be(ns_last[1]), .prev_be(ns_prev[1]));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wide_op(input int i, input logic wr, input logic [15:0] a,
                           input logic [31:0] d, input logic [3:0] be,
                           output logic [31:0] rd, output int waits, output int pulses);
        @(negedge clk);
        w_addr[i] = a; w_wdata[i] = d; w_be[i] = be; w_wr[i] = wr; w_rd[i] = !wr;
        waits = 0; pulses = 0; rd = '0;
        forever begin
            pulses += int'(w_valid[i]);
            if (!w_wait[i]) begin
                rd = w_rdata[i];
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        w_wr[i] = 1'b0; w_rd[i] = 1'b0;
        pulses += int'(w_valid[i]);
    endtask

    task automatic narrow_op(input int i, input logic wr, input logic [15:0] a,
                             input logic [15:0] d, input logic [1:0] be,
                             output logic [15:0] rd, output int waits, output int pulses);
        @(negedge clk);
        n_addr[i] = a; n_wdata[i] = d; n_be[i] = be; n_wr[i] = wr; n_rd[i] = !wr;
        waits = 0; pulses = 0; rd = '0;
        forever begin
            pulses += int'(n_valid[i]);
            if (!n_wait[i]) begin
                rd = n_rdata[i];
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        n_wr[i] = 1'b0; n_rd[i] = 1'b0;
        pulses += int'(n_valid[i]);
    endtask

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    // stimulus table for uut: {address, write data, byte enables}
    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{16'h0000, 32'h11223344, 4'hF},
        '{16'h0004, 32'hA5A55A5A, 4'h3},
        '{16'h0008, 32'hDEADBEEF, 4'hC},
        '{16'h000C, 32'h0F0E0D0C, 4'h5}
    };

    initial begin
        repeat (25000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r32;
        logic [15:0] r16;
        int waits, pulses, n0;
        for (int i = 0; i < 2; i++) begin
            w_addr[i] = '0; w_wdata[i] = '0; w_be[i] = '0; w_rd[i] = 0; w_wr[i] = 0;
            n_addr[i] = '0; n_wdata[i] = '0; n_be[i] = '0; n_rd[i] = 0; n_wr[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 waitreq in reset", {28'd0, w_wait[0], w_wait[1], n_wait[0], n_wait[1]}, 32'hF);
        chk("R1 rdvalid in reset", {28'd0, w_valid[0], w_valid[1], n_valid[0], n_valid[1]}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle slave requests", {28'd0, ws_rd[0] | ws_wr[0], ws_rd[1] | ws_wr[1],
                                       ns_rd[0] | ns_wr[0], ns_rd[1] | ns_wr[1]}, 32'h0);
        chk("R1 waitreq idle", {31'd0, w_wait[0]}, 32'h1);

        // table walk on the splitting bridge with 2 slave wait cycles
        foreach (VECS[k]) begin
            n0 = ws_ntx[0];
            wide_op(0, 1'b1, VECS[k].addr, VECS[k].data, VECS[k].be, r32, waits, pulses);
            chk("R2 two slave writes", 32'(ws_ntx[0] - n0), 32'd2);
            chk("R3 low slice enables", {30'd0, ws_prev[0]}, {30'd0, VECS[k].be[1:0]});
            chk("R3 high slice enables", {30'd0, ws_last[0]}, {30'd0, VECS[k].be[3:2]});
            chk("R8 write stall length", 32'(waits), 32'd7);
            chk("R9 no valid on write", 32'(pulses), 32'd0);
            n0 = ws_ntx[0];
            wide_op(0, 1'b0, VECS[k].addr, 32'h0, 4'hF, r32, waits, pulses);
            chk("R2 read assembled", r32, VECS[k].data & be_mask(VECS[k].be));
            chk("R2 two slave reads", 32'(ws_ntx[0] - n0), 32'd2);
            chk("R9 one valid on read", 32'(pulses), 32'd1);
            chk("R8 read stall length", 32'(waits), 32'd7);
        end
        // R2: lowest slave word holds least significant half
        chk("R2 word order low", {16'd0, sw0.mem[0]}, 32'h3344);
        chk("R2 word order high", {16'd0, sw0.mem[1]}, 32'h1122);

        // native, wide master
        n0 = ws_ntx[1];
        wide_op(1, 1'b1, 16'h0004, 32'hAABBCCDD, 4'hF, r32, waits, pulses);
        chk("R6 single slave access", 32'(ws_ntx[1] - n0), 32'd1);
        chk("R6 low data at master address", {16'd0, sw1.mem[2]}, 32'hCCDD);
        chk("R6 upper word untouched", {16'd0, sw1.mem[3]}, 32'h0);
        chk("R8 native stall length", 32'(waits), 32'd2);
        wide_op(1, 1'b0, 16'h0004, 32'h0, 4'hF, r32, waits, pulses);
        chk("R6 zero padded read", r32, 32'h0000CCDD);
        chk("R9 native valid pulse", 32'(pulses), 32'd1);

        // sizing, narrow master (1 wait cycle)
        narrow_op(0, 1'b1, 16'h0002, 16'h1234, 2'b11, r16, waits, pulses);
        chk("R4 upper lane enables", {28'd0, ns_last[0]}, 32'hC);
        chk("R4 upper lane data", sn0.mem[0], 32'h12340000);
        chk("R8 narrow stall length", 32'(waits), 32'd3);
        narrow_op(0, 1'b1, 16'h0000, 16'hBEEF, 2'b01, r16, waits, pulses);
        chk("R4 single byte enable", {28'd0, ns_last[0]}, 32'h1);
        chk("R4 merged word", sn0.mem[0], 32'h123400EF);
        narrow_op(0, 1'b1, 16'h0006, 16'h7700, 2'b10, r16, waits, pulses);
        chk("R4 top byte enable", {28'd0, ns_last[0]}, 32'h8);
        chk("R4 second word", sn0.mem[1], 32'h77000000);
        narrow_op(0, 1'b0, 16'h0002, 16'h0, 2'b11, r16, waits, pulses);
        chk("R5 read upper lane", {16'd0, r16}, 32'h1234);
        narrow_op(0, 1'b0, 16'h0000, 16'h0, 2'b11, r16, waits, pulses);
        chk("R5 read lower lane", {16'd0, r16}, 32'h00EF);
        chk("R9 narrow valid pulse", 32'(pulses), 32'd1);

        // native, narrow master
        narrow_op(1, 1'b1, 16'h0006, 16'h5678, 2'b11, r16, waits, pulses);
        chk("R7 low lane enables", {28'd0, ns_last[1]}, 32'h3);
        chk("R7 unshifted data", sn1.mem[1], 32'h00005678);
        narrow_op(1, 1'b0, 16'h0004, 16'h0, 2'b11, r16, waits, pulses);
        chk("R7 read aligned address", {16'd0, r16}, 32'h5678);
        narrow_op(1, 1'b0, 16'h0006, 16'h0, 2'b11, r16, waits, pulses);
        chk("R7 read dropped bits", {16'd0, r16}, 32'h5678);

        @(negedge clk);
        chk("R1 idle after traffic", {28'd0, w_wait[0], w_wait[1], n_wait[0], n_wait[1]}, 32'hF);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule